// File: doc/BRIEF.md
# Five-Channel Down-Counting PWM Timer

A timer peripheral with five channels behind a simple word-addressed register bus. Each channel owns a down-counter that is loaded from a software-written count buffer. Channels 0 to 3 also own a compare register, loaded from a compare buffer, and a PWM output pin. When a decrement lands on the compare value, the channel's output level goes high. A reload, whether manual or automatic, returns the level to low. Channel 4 is a plain down-counter with no compare and no pin.

Software writes the buffers and then pulses a per-channel update bit (set, then clear) to copy them into the working registers. With auto-reload enabled, a channel reloads its counter from the count buffer on the tick after it reaches zero, which gives a continuous PWM waveform. Counting is paced by two shared 8-bit prescalers: one serves channels 0 and 1, the other serves channels 2, 3 and 4. Each channel then applies its own power-of-two divider.

Top module: `pwm5_timer`

## Requirements
- R1: After reset, every register, counter, compare value and output level is zero, and `pwm_o` is 0.
- R2: While a channel's start bit is set, each channel tick decrements its counter by one. A counter at zero with auto-reload clear stays at zero.
- R3: A channel's output level goes high on a tick whose decrement produces the compare value. The level goes low on a manual update or an auto-reload. If the compare value equals the count value, the level never goes high.
- R4: While a channel's update bit is set, the counter takes the count buffer, the compare register takes the compare buffer, and the level is cleared, every cycle.
- R5: With auto-reload set, a tick that finds the counter at zero loads the count buffer. The auto-reload bit is bit 2 of the channel field for channels 0 to 3 and bit 19 for channel 4. Bit 18 is stored but has no function.
- R6: With start and update both clear, the counter and the output level hold.
- R7: A channel ticks once every (P+1)·D input clocks. P is prescaler 0 (config0 bits [7:0]) for channels 0 and 1, and prescaler 1 (config0 bits [15:8]) for channels 2 to 4. D is 1, 2, 4, 8 or 16 for divider-select values 0 to 4, and 16 for any larger value. The divider select for channel i is config1 bits [4i+3:4i].
- R8: Writing a count or compare buffer does not change the counter, the compare value or the pin until the next update or reload.
- R9: Register map, by word address: 0 is config0, 1 is config1, 2 is control, 3+3i is the count buffer of channel i, 4+3i is the compare buffer of channel i (channels 0 to 3), and 5+3i is the live counter of channel i (read-only, writes ignored). In the control register, channel i (0 to 3) uses bit 4i for start, 4i+1 for update, 4i+2 for auto-reload and 4i+3 for invert. Channel 4 uses bit 16 for start and bit 17 for update.
- R10: `pwm_o[i]` equals the output level XOR the invert bit of channel i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_o | output | 4 | PWM pins of channels 0 to 3 |

## Verification
A counter that skips, doubles or misses a decrement shows in the live-count register after the next channel tick. The bench starts and stops channels for exact cycle counts and reads that register back. A wrong compare or reload state shows on the pin within one PWM period, so the bench measures the high and low lengths over whole periods and compares them with (C+1)·(P+1)·D and (N−C)·(P+1)·D. A tick that comes from the wrong prescaler group or divider stretches both lengths by the wrong factor within the first period.

// File: rtl/pwm5_pkg.sv
package pwm5_pkg;
    // control field layout, 4 bits per channel
    localparam int CTL_FW       = 4;
    localparam int CTL_START    = 0;
    localparam int CTL_UPD      = 1;
    localparam int CTL_ARL      = 2;
    localparam int CTL_INV      = 3;
    // the last channel has no inverter; its reload bit sits in that slot
    localparam int CTL_ARL_LAST = 3;
    // register map
    localparam int ADDR_CFG0    = 0;
    localparam int ADDR_CFG1    = 1;
    localparam int ADDR_CTRL    = 2;
    localparam int ADDR_BASE    = 3;
    localparam int ADDR_STRIDE  = 3;
endpackage

// File: rtl/pwm5_presc.sv
module pwm5_presc #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] pre,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == '0);
        cnt_d = tick ? pre : cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm5_div.sv
module pwm5_div #(
    parameter int DSW       = 4,
    parameter int MAX_SHIFT = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           grp_tick,
    input  logic [DSW-1:0] sel,
    output logic           tick
);
    logic [MAX_SHIFT-1:0] dcnt_d, dcnt_q;
    logic [MAX_SHIFT-1:0] mask;

    always_comb begin
        if (sel >= DSW'(MAX_SHIFT)) mask = '1;
        else                        mask = MAX_SHIFT'((1 << sel) - 1);
        tick   = grp_tick && ((dcnt_q & mask) == mask);
        dcnt_d = grp_tick ? dcnt_q + 1'b1 : dcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcnt_q <= '0;
        else        dcnt_q <= dcnt_d;
    end
endmodule

// File: rtl/pwm5_chan.sv
module pwm5_chan #(
    parameter int CW      = 16,
    parameter bit HAS_CMP = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic          upd,
    input  logic          arl,
    input  logic          inv,
    input  logic [CW-1:0] cbuf,
    input  logic [CW-1:0] pbuf,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cmp,
    output logic          lvl,
    output logic          pin
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] cmp;
        logic          lvl;
    } chan_t;

    chan_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (upd) begin
            s_d.cnt = cbuf;
            s_d.cmp = HAS_CMP ? pbuf : '0;
            s_d.lvl = 1'b0;
        end else if (start && tick) begin
            if (s_q.cnt == '0) begin
                if (arl) begin
                    s_d.cnt = cbuf;
                    s_d.lvl = 1'b0;
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
                // match is tested only on the decremented value
                if (HAS_CMP && (s_d.cnt == s_q.cmp)) s_d.lvl = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt = s_q.cnt;
    assign cmp = s_q.cmp;
    assign lvl = s_q.lvl;
    assign pin = s_q.lvl ^ (inv & HAS_CMP);
endmodule

// File: rtl/pwm5_timer.sv
module pwm5_timer
    import pwm5_pkg::*;
#(
    parameter int NCH       = 5,
    parameter int CW        = 16,
    parameter int PW        = 8,
    parameter int DSW       = 4,
    parameter int MAX_SHIFT = 4,
    parameter int GRP0_N    = 2,
    parameter int AW        = 5,
    parameter int BW        = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [BW-1:0]   bus_wdata,
    output logic [BW-1:0]   bus_rdata,
    output logic [NCH-2:0]  pwm_o
);
    localparam int NOUT   = NCH - 1;
    localparam int CFG0_W = 2 * PW;
    localparam int CFG1_W = NCH * DSW;
    localparam int CTRL_W = NCH * CTL_FW;

    typedef struct packed {
        logic [CFG0_W-1:0]          cfg0;
        logic [CFG1_W-1:0]          cfg1;
        logic [CTRL_W-1:0]          ctrl;
        logic [NCH-1:0][CW-1:0]     cbuf;
        logic [NOUT-1:0][CW-1:0]    pbuf;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]             grp_tick;
    logic [NCH-1:0]         ch_tick, ch_start, ch_upd, ch_arl, ch_lvl;
    logic [NCH-1:0][CW-1:0] ch_cnt, ch_cmp, ch_cbuf;

    wire unused_wdata = ^bus_wdata[BW-1:CTRL_W];

    // register writes
    always_comb begin
        r_d = r_q;
        if (bus_we) begin
            if (bus_addr == AW'(ADDR_CFG0)) r_d.cfg0 = bus_wdata[CFG0_W-1:0];
            if (bus_addr == AW'(ADDR_CFG1)) r_d.cfg1 = bus_wdata[CFG1_W-1:0];
            if (bus_addr == AW'(ADDR_CTRL)) r_d.ctrl = bus_wdata[CTRL_W-1:0];
            for (int i = 0; i < NCH; i++)
                if (bus_addr == AW'(ADDR_BASE + ADDR_STRIDE * i))
                    r_d.cbuf[i] = bus_wdata[CW-1:0];
            for (int i = 0; i < NOUT; i++)
                if (bus_addr == AW'(ADDR_BASE + ADDR_STRIDE * i + 1))
                    r_d.pbuf[i] = bus_wdata[CW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // register reads
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CFG0)) bus_rdata = BW'(r_q.cfg0);
        if (bus_addr == AW'(ADDR_CFG1)) bus_rdata = BW'(r_q.cfg1);
        if (bus_addr == AW'(ADDR_CTRL)) bus_rdata = BW'(r_q.ctrl);
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == AW'(ADDR_BASE + ADDR_STRIDE * i))
                bus_rdata = BW'(r_q.cbuf[i]);
            if (bus_addr == AW'(ADDR_BASE + ADDR_STRIDE * i + 2))
                bus_rdata = BW'(ch_cnt[i]);
        end
        for (int i = 0; i < NOUT; i++)
            if (bus_addr == AW'(ADDR_BASE + ADDR_STRIDE * i + 1))
                bus_rdata = BW'(r_q.pbuf[i]);
    end

    for (genvar g = 0; g < 2; g++) begin : g_presc
        pwm5_presc #(.PW(PW)) u_presc (
            .clk  (clk),
            .rst_n(rst_n),
            .pre  (r_q.cfg0[g*PW +: PW]),
            .tick (grp_tick[g])
        );
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        localparam bit LAST = (i == NCH - 1);
        logic          pin_w;
        logic          inv_w;
        logic [CW-1:0] pbuf_w;

        assign ch_cbuf[i]  = r_q.cbuf[i];
        assign ch_start[i] = r_q.ctrl[CTL_FW*i + CTL_START];
        assign ch_upd[i]   = r_q.ctrl[CTL_FW*i + CTL_UPD];

        if (LAST) begin : g_plain
            logic unused_pin;
            assign ch_arl[i]  = r_q.ctrl[CTL_FW*i + CTL_ARL_LAST];
            assign inv_w      = 1'b0;
            assign pbuf_w     = '0;
            assign unused_pin = pin_w;
        end else begin : g_out
            assign ch_arl[i] = r_q.ctrl[CTL_FW*i + CTL_ARL];
            assign inv_w     = r_q.ctrl[CTL_FW*i + CTL_INV];
            assign pbuf_w    = r_q.pbuf[i];
            assign pwm_o[i]  = pin_w;
        end

        pwm5_div #(.DSW(DSW), .MAX_SHIFT(MAX_SHIFT)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .grp_tick(grp_tick[(i < GRP0_N) ? 0 : 1]),
            .sel     (r_q.cfg1[DSW*i +: DSW]),
            .tick    (ch_tick[i])
        );

        pwm5_chan #(.CW(CW), .HAS_CMP(!LAST)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .tick (ch_tick[i]),
            .start(ch_start[i]),
            .upd  (ch_upd[i]),
            .arl  (ch_arl[i]),
            .inv  (inv_w),
            .cbuf (ch_cbuf[i]),
            .pbuf (pbuf_w),
            .cnt  (ch_cnt[i]),
            .cmp  (ch_cmp[i]),
            .lvl  (ch_lvl[i]),
            .pin  (pin_w)
        );
    end
endmodule

// File: rtl/pwm5_timer_chk.sv
module pwm5_timer_chk #(
    parameter int NCH = 5,
    parameter int CW  = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         ch_tick,
    input logic [NCH-1:0]         ch_start,
    input logic [NCH-1:0]         ch_upd,
    input logic [NCH-1:0]         ch_arl,
    input logic [NCH-1:0]         ch_lvl,
    input logic [NCH-1:0][CW-1:0] ch_cnt,
    input logic [NCH-1:0][CW-1:0] ch_cmp,
    input logic [NCH-1:0][CW-1:0] ch_cbuf
);
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        // R2
        count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[i] && ch_start[i] && !ch_upd[i] && ch_cnt[i] != '0)
            |=> ch_cnt[i] == CW'($past(ch_cnt[i]) - 1'b1));
        // R3
        rise_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_lvl[i]) |-> ch_cnt[i] == ch_cmp[i]);
        // R4
        manual_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ch_upd[i] |=> (ch_cnt[i] == $past(ch_cbuf[i])) && !ch_lvl[i]);
        // R5
        auto_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tick[i] && ch_start[i] && !ch_upd[i] && ch_arl[i] && ch_cnt[i] == '0)
            |=> ch_cnt[i] == $past(ch_cbuf[i]));
        // R6
        hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_start[i] && !ch_upd[i]) |=> $stable(ch_cnt[i]) && $stable(ch_lvl[i]));
    end
endmodule

bind pwm5_timer pwm5_timer_chk #(.NCH(NCH), .CW(CW)) u_pwm5_timer_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ch_tick (ch_tick),
    .ch_start(ch_start),
    .ch_upd  (ch_upd),
    .ch_arl  (ch_arl),
    .ch_lvl  (ch_lvl),
    .ch_cnt  (ch_cnt),
    .ch_cmp  (ch_cmp),
    .ch_cbuf (ch_cbuf)
);

// File: tb/test_pwm5_timer.sv
module test_pwm5_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    pwm5_timer i_pwm5_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .pwm_o    (pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = 5'(a);
        bus_wdata = 32'(d);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        bus_addr = 5'(a);
        #1;
        d = int'(bus_rdata);
    endtask

    function automatic int div_of(input int sel);
        return (sel >= 4) ? 16 : (1 << sel);
    endfunction

    // control word: channels 0..3 use bits 4i..4i+3 = start, update, reload, invert;
    // channel 4 uses bit 16 start, 17 update, 19 reload
    function automatic int ctl(input int ch, input int st, input int up, input int ar, input int inv);
        if (ch == 4) return (st << 16) | (up << 17) | (ar << 19);
        return (st | (up << 1) | (ar << 2) | (inv << 3)) << (4 * ch);
    endfunction

    task automatic measure(input int ch, output int hi, output int lo);
        bit prev, cur, found;
        found = 1'b0;
        hi = -1;
        lo = -1;
        @(negedge clk);
        prev = pwm_o[ch];
        for (int g = 0; g < 20000; g++) begin
            @(negedge clk);
            cur = pwm_o[ch];
            if (!prev && cur) begin found = 1'b1; break; end
            prev = cur;
        end
        if (found) begin
            hi = 1;
            for (int g = 0; g < 20000; g++) begin
                @(negedge clk);
                if (pwm_o[ch]) hi++; else break;
            end
            lo = 1;
            for (int g = 0; g < 20000; g++) begin
                @(negedge clk);
                if (!pwm_o[ch]) lo++; else break;
            end
        end
    endtask

    task automatic period_trial(input int ch, input int p0, input int p1, input int sel,
                                input int n, input int c, input string tag);
        int hi, lo, p, d;
        wr(0, p0 | (p1 << 8));
        wr(1, sel << (4 * ch));
        wr(3 + 3 * ch, n);
        wr(4 + 3 * ch, c);
        wr(2, ctl(ch, 0, 1, 1, 0));
        wr(2, ctl(ch, 1, 0, 1, 0));
        measure(ch, hi, lo);
        p = (ch < 2) ? p0 : p1;
        d = div_of(sel);
        chk({"R7 high length ", tag}, hi, (c + 1) * (p + 1) * d);
        chk({"R3 low length ", tag}, lo, (n - c) * (p + 1) * d);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v, highs;
        void'($urandom(32'h5eed_0017));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 pwm_o after reset", int'(pwm_o), 0);
        rd(5, v);  chk("R1 counter 0 after reset", v, 0);
        rd(2, v);  chk("R1 control after reset", v, 0);

        // R4 / R9 manual update and map
        wr(0, 0);
        wr(1, 0);
        wr(3, 100);
        wr(4, 40);
        wr(2, ctl(0, 0, 1, 0, 0));
        wr(2, ctl(0, 0, 0, 0, 0));
        rd(5, v);  chk("R4 counter after update", v, 100);
        rd(4, v);  chk("R9 compare buffer readback", v, 40);
        wr(5, 1234);
        rd(5, v);  chk("R9 live count is read-only", v, 100);

        // R2 exactly 8 decrements
        wr(2, ctl(0, 1, 0, 0, 0));
        repeat (6) @(negedge clk);
        wr(2, 0);
        rd(5, v);  chk("R2 counter after 8 ticks", v, 92);

        // R6 stopped holds
        repeat (20) @(negedge clk);
        rd(5, v);  chk("R6 counter holds while stopped", v, 92);
        chk("R6 pin holds while stopped", int'(pwm_o[0]), 0);

        // R8 buffer writes have no effect yet
        wr(3, 7);
        wr(4, 3);
        rd(5, v);  chk("R8 counter unchanged by buffer write", v, 92);
        chk("R8 pin unchanged by buffer write", int'(pwm_o[0]), 0);

        // R2 / R3 run to zero without reload
        wr(2, ctl(0, 0, 1, 0, 0));
        wr(2, ctl(0, 1, 0, 0, 0));
        repeat (30) @(negedge clk);
        rd(5, v);  chk("R2 counter rests at zero", v, 0);
        chk("R3 pin high after match", int'(pwm_o[0]), 1);

        // R10 inverter
        wr(2, ctl(0, 0, 0, 0, 1));
        chk("R10 inverted pin", int'(pwm_o[0]), 0);
        wr(2, 0);
        chk("R10 pin restored", int'(pwm_o[0]), 1);

        // R3 compare equal to count never toggles
        wr(3, 6);
        wr(4, 6);
        wr(2, ctl(0, 0, 1, 1, 0));
        wr(2, ctl(0, 1, 0, 1, 0));
        highs = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (pwm_o[0]) highs++;
        end
        chk("R3 equal compare never high", highs, 0);
        wr(2, 0);

        // R5 channel 4 reload via bit 19
        wr(15, 5);
        wr(2, ctl(4, 0, 1, 1, 0));
        wr(2, ctl(4, 1, 0, 1, 0));
        repeat (14) @(negedge clk);
        wr(2, ctl(4, 0, 0, 1, 0));
        rd(17, v); chk("R5 ch4 counter after 16 ticks with reload", v, 1);
        // bit 18 does not reload channel 4
        wr(2, (1 << 17) | (1 << 18));
        wr(2, (1 << 16) | (1 << 18));
        repeat (14) @(negedge clk);
        wr(2, 1 << 18);
        rd(17, v); chk("R5 ch4 bit 18 gives no reload", v, 0);

        // R7 directed: channel 2 on prescaler 1
        period_trial(2, 0, 3, 2, 4, 1, "directed ch2");
        // R7 divider select above 4 behaves as 16
        period_trial(1, 1, 0, 9, 3, 0, "sel 9 ch1");

        // R7 random trials
        for (int t = 0; t < 12; t++) begin
            int ch, p0, p1, sel, n, c;
            ch  = int'($urandom % 4);
            p0  = int'($urandom % 4);
            p1  = int'($urandom % 4);
            sel = int'($urandom % 8);
            n   = 2 + int'($urandom % 19);
            c   = int'($urandom % n);
            period_trial(ch, p0, p1, sel, n, c, "random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule